// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block collects nineteen request lines from the processor core and its peripherals. It keeps a pending flag for each line and picks the single most urgent source that may be serviced. It then presents that source's vector address, its level and its index to the core. Six core exceptions form a non-maskable level (level 1). The two external request pins and seven peripheral channels form a maskable level (level 0). The maskable level is blocked as a whole by the core's mask bit. Each external pin and each peripheral channel is gated by its own field in a 16-bit configuration word.

The two reset vectors depend on the two-bit operating mode. All other vectors are fixed. The presentation registers load on every clock from the pending state as it stands after that clock. So when the core acknowledges a source, that source's flag is dropped and the next source takes its place in the same cycle.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source indices, from most to least urgent, are: 0 hardware reset, 1 watchdog reset, 2 illegal instruction, 3 stack overflow, 4 debug trap, 5 software trap, 6 external A, 7 external B, 8-11 serial receive-with-exception / receive / transmit-with-exception / transmit, 12-14 timer 0/1/2 overflow, 15 second SPI, 16 first SPI, 17 real-time timer, 18 port-B GPIO. Among eligible pending sources, the lowest index is presented. `irqLevel` is 1 for indices 0-5 and 0 otherwise.
- R2: The fixed vectors are: index 2 0x0006, 5 0x0008, 3 0x000A, 4 0x000C, 6 0x0010, 7 0x0012, 18 0x0014, 17 0x0016, 12-14 0x0018+2k, 8-11 0x0020+2k, 15 0x0028, 16 0x002A.
- R3: Index 0 gives vector 0x0000, 0x7F80 or 0xE000 in modes 0, 1 and 2. Index 1 gives 0x0002, 0x7F82 or 0xE002. Mode 3 gives the same vectors as mode 0.
- R4: A valid output never carries 0x0004, 0x000E or 0x001E.
- R5: External A is eligible only while config bits 2:1 are nonzero, and external B only while bits 5:4 are nonzero. Any nonzero value enables the pin.
- R6: Config bit 9 enables the serial sources, bit 11 the timer sources, bit 12 the second SPI, bit 13 the first SPI, bit 14 the real-time timer and bit 15 the GPIO. Bit 10 belongs to an unused channel.
- R7: While `coreMask` is 1, no level-0 source is presented. Level-1 sources are presented regardless of the mask.
- R8: A pending flag is set by a rising request edge. It stays set while the source is disabled or masked. It is cleared only by `irqAck` while that source is presented. A request held high does not set the flag again.
- R9: Outputs are registered. A request edge, or a config or mask change, seen at one clock edge is reflected after that edge. An acknowledge replaces the presented source with the next eligible one after the same edge.
- R10: During reset all outputs are 0. After reset, only the flag of the reset cause is pending: index 1 if `copCause` is 1, otherwise index 0.
- R11: When nothing is presented, `irqVector`, `irqLevel` and `irqSrc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| copCause | input | 1 | Reset was caused by the watchdog (sampled during reset) |
| srcReq | input | 19 | Request line per source index |
| opMode | input | 2 | Operating mode, selects reset vectors |
| prioReg | input | 16 | Enable configuration word |
| coreMask | input | 1 | Blocks all level-0 sources when 1 |
| irqAck | input | 1 | Acknowledges the presented source |
| irqValid | output | 1 | A source is presented |
| irqVector | output | 16 | Vector address of the presented source |
| irqLevel | output | 1 | 1 = non-maskable, 0 = maskable |
| irqSrc | output | 5 | Index of the presented source |

## Verification
Every source is raised alone in each operating mode. This separates vector, level and index errors per source, and shows the mode-dependent reset vectors and the mode-3 fallback. Every ordered pair of sources is raised in the same cycle and then acknowledged twice. This exposes any priority inversion and any clearing of the wrong flag. Each maskable source is raised with its enable removed and is released afterwards, which tells gating apart from loss of the pending flag. The external-pin fields are tried with all three nonzero values, and the mask is applied to mixed-level traffic.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC    = 19;
  localparam int SRC_W   = $clog2(NSRC);
  localparam int ADDR_W  = 16;
  localparam int CFG_W   = 16;
  localparam int MODE_W  = 2;
  localparam int NUM_NMI = 6;

  typedef enum logic [SRC_W-1:0] {
    SRC_HWRST, SRC_WDRST, SRC_ILLEGAL, SRC_STKOVF, SRC_DBGTRAP, SRC_SWTRAP,
    SRC_EXTA, SRC_EXTB,
    SRC_SSRXE, SRC_SSRX, SRC_SSTXE, SRC_SSTX,
    SRC_TMR0, SRC_TMR1, SRC_TMR2,
    SRC_SPIB, SRC_SPIA, SRC_RTT, SRC_GPIOB
  } srcIdT;

  typedef struct packed {
    logic [NSRC-1:0] pendNext;
    logic            ackTaken;
  } ctrlStrobeT;

  function automatic logic [ADDR_W-1:0] resetBase(input logic [MODE_W-1:0] m);
    case (m)
      2'd1:    return ADDR_W'(16'h7F80);
      2'd2:    return ADDR_W'(16'hE000);
      default: return '0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] vectorOf(input int s, input logic [MODE_W-1:0] m);
    if (s == int'(SRC_HWRST)) return resetBase(m);
    if (s == int'(SRC_WDRST)) return resetBase(m) + ADDR_W'(2);
    if (s >= int'(SRC_SSRXE) && s <= int'(SRC_SSTX))
      return ADDR_W'(32'h20 + 2 * (s - int'(SRC_SSRXE)));
    if (s >= int'(SRC_TMR0) && s <= int'(SRC_TMR2))
      return ADDR_W'(32'h18 + 2 * (s - int'(SRC_TMR0)));
    case (s)
      int'(SRC_ILLEGAL): return ADDR_W'(16'h0006);
      int'(SRC_SWTRAP):  return ADDR_W'(16'h0008);
      int'(SRC_STKOVF):  return ADDR_W'(16'h000A);
      int'(SRC_DBGTRAP): return ADDR_W'(16'h000C);
      int'(SRC_EXTA):    return ADDR_W'(16'h0010);
      int'(SRC_EXTB):    return ADDR_W'(16'h0012);
      int'(SRC_GPIOB):   return ADDR_W'(16'h0014);
      int'(SRC_RTT):     return ADDR_W'(16'h0016);
      int'(SRC_SPIB):    return ADDR_W'(16'h0028);
      int'(SRC_SPIA):    return ADDR_W'(16'h002A);
      default:           return '0;
    endcase
  endfunction

  // Channel n is enabled by config bit (15 - n); external pins by 2-bit fields.
  function automatic logic srcEnabled(input int s, input logic [CFG_W-1:0] cfg);
    if (s < NUM_NMI) return 1'b1;
    if (s == int'(SRC_EXTA)) return |cfg[2:1];
    if (s == int'(SRC_EXTB)) return |cfg[5:4];
    if (s >= int'(SRC_SSRXE) && s <= int'(SRC_SSTX)) return cfg[9];
    if (s >= int'(SRC_TMR0) && s <= int'(SRC_TMR2)) return cfg[11];
    case (s)
      int'(SRC_SPIB):  return cfg[12];
      int'(SRC_SPIA):  return cfg[13];
      int'(SRC_RTT):   return cfg[14];
      int'(SRC_GPIOB): return cfg[15];
      default:         return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  elig,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |elig;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             copCause,
  input  logic [NSRC-1:0]  srcReq,
  input  logic             irqAck,
  input  logic             curValid,
  input  logic [SRC_W-1:0] curSrc,
  output ctrlStrobeT       strobe
);
  logic [NSRC-1:0] prevReq;
  logic [NSRC-1:0] pending;
  logic [NSRC-1:0] setVec;
  logic [NSRC-1:0] clrVec;
  logic            ackTaken;

  assign ackTaken = irqAck && curValid;
  assign setVec   = srcReq & ~prevReq;

  always_comb begin
    clrVec = '0;
    if (ackTaken) clrVec[curSrc] = 1'b1;
  end

  assign strobe.pendNext = (pending & ~clrVec) | setVec;
  assign strobe.ackTaken = ackTaken;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevReq <= '0;
      pending <= '0;
      pending[copCause ? int'(SRC_WDRST) : int'(SRC_HWRST)] <= 1'b1;
    end else begin
      prevReq <= srcReq;
      pending <= strobe.pendNext;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : gChk
    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pending[g]) |-> $past(irqAck && curValid && (curSrc == SRC_W'(g))));
    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(srcReq[g]) |=> pending[g]);
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [MODE_W-1:0] opMode,
  input  logic [CFG_W-1:0]  prioReg,
  input  logic              coreMask,
  output logic              irqValid,
  output logic [ADDR_W-1:0] irqVector,
  output logic              irqLevel,
  output logic [SRC_W-1:0]  irqSrc
);
  logic [NSRC-1:0] enMask;
  logic [NSRC-1:0] elig;
  logic            selAny;
  logic [SRC_W-1:0] selIdx;
  logic [ADDR_W-1:0] selVec;

  for (genvar g = 0; g < NSRC; g++) begin : gEn
    if (g < NUM_NMI) begin : gNmi
      assign enMask[g] = 1'b1;
    end else begin : gMask
      assign enMask[g] = srcEnabled(g, prioReg) && !coreMask;
    end
  end

  assign elig = strobe.pendNext & enMask;

  irqc_pick #(.N(NSRC)) uPick (
    .elig (elig),
    .any  (selAny),
    .idx  (selIdx)
  );

  always_comb begin
    selVec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (selIdx == SRC_W'(i)) selVec = vectorOf(i, opMode);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqValid  <= 1'b0;
      irqVector <= '0;
      irqLevel  <= 1'b0;
      irqSrc    <= '0;
    end else begin
      irqValid  <= selAny;
      irqVector <= selAny ? selVec : '0;
      irqLevel  <= selAny && (selIdx < SRC_W'(NUM_NMI));
      irqSrc    <= selAny ? selIdx : '0;
    end
  end

  // R4
  no_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqVector != 16'h0004 && irqVector != 16'h000E && irqVector != 16'h001E));
  // R7
  mask_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && !irqLevel) |-> !$past(coreMask));
  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> (irqVector == '0 && !irqLevel && irqSrc == '0));
  // R1
  level_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqLevel == (irqSrc < SRC_W'(NUM_NMI))));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              copCause,
  input  logic [NSRC-1:0]   srcReq,
  input  logic [MODE_W-1:0] opMode,
  input  logic [CFG_W-1:0]  prioReg,
  input  logic              coreMask,
  input  logic              irqAck,
  output logic              irqValid,
  output logic [ADDR_W-1:0] irqVector,
  output logic              irqLevel,
  output logic [SRC_W-1:0]  irqSrc
);
  ctrlStrobeT strobe;

  irqc_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .copCause (copCause),
    .srcReq   (srcReq),
    .irqAck   (irqAck),
    .curValid (irqValid),
    .curSrc   (irqSrc),
    .strobe   (strobe)
  );

  irqc_datapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opMode    (opMode),
    .prioReg   (prioReg),
    .coreMask  (coreMask),
    .irqValid  (irqValid),
    .irqVector (irqVector),
    .irqLevel  (irqLevel),
    .irqSrc    (irqSrc)
  );
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  localparam int NS = 19;
  localparam logic [15:0] CFG_ALL = 16'hFE36;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        copCause = 1'b0;
  logic [NS-1:0] srcReq = '0;
  logic [1:0]  opMode = 2'd0;
  logic [15:0] prioReg = CFG_ALL;
  logic        coreMask = 1'b0;
  logic        irqAck = 1'b0;
  logic        irqValid;
  logic [15:0] irqVector;
  logic        irqLevel;
  logic [4:0]  irqSrc;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rstN(rstN), .copCause(copCause), .srcReq(srcReq),
    .opMode(opMode), .prioReg(prioReg), .coreMask(coreMask), .irqAck(irqAck),
    .irqValid(irqValid), .irqVector(irqVector), .irqLevel(irqLevel), .irqSrc(irqSrc)
  );

  function automatic logic [15:0] expVec(input int s, input logic [1:0] m);
    logic [15:0] base;
    base = (m == 2'd1) ? 16'h7F80 : (m == 2'd2) ? 16'hE000 : 16'h0000;
    if (s == 0) return base;
    if (s == 1) return base + 16'd2;
    if (s >= 8 && s <= 11) return 16'(32'h20 + 2 * (s - 8));
    if (s >= 12 && s <= 14) return 16'(32'h18 + 2 * (s - 12));
    case (s)
      2: return 16'h0006;  3: return 16'h000A;  4: return 16'h000C;
      5: return 16'h0008;  6: return 16'h0010;  7: return 16'h0012;
      15: return 16'h0028; 16: return 16'h002A; 17: return 16'h0016;
      default: return 16'h0014;
    endcase
  endfunction

  function automatic logic [15:0] enBits(input int s);
    if (s == 6) return 16'h0006;
    if (s == 7) return 16'h0030;
    if (s >= 8 && s <= 11) return 16'h0200;
    if (s >= 12 && s <= 14) return 16'h0800;
    return 16'(1 << (s - 3));
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic expectOut(input string tag, input bit v, input int s);
    logic [15:0] ev;
    ev = v ? expVec(s, opMode) : 16'h0;
    chk(irqValid == v, {tag, " valid"}, 32'(irqValid), 32'(v));
    chk(irqVector == ev, {tag, " vector"}, 32'(irqVector), 32'(ev));
    chk(irqLevel == (v && s < 6), {tag, " level"}, 32'(irqLevel), 32'(v && s < 6));
    chk(irqSrc == (v ? 5'(s) : 5'd0), {tag, " src"}, 32'(irqSrc), v ? 32'(s) : 32'd0);
    // R4 reserved addresses
    chk(!(irqValid && (irqVector == 16'h4 || irqVector == 16'hE || irqVector == 16'h1E)),
        "R4 reserved vector", 32'(irqVector), 32'h0);
  endtask

  task automatic pulse(input int s);
    srcReq[s] = 1'b1;
    step();
    srcReq[s] = 1'b0;
  endtask

  task automatic ackOne();
    irqAck = 1'b1;
    step();
    irqAck = 1'b0;
  endtask

  task automatic doReset(input bit cop, input logic [1:0] m);
    rstN = 1'b0; copCause = cop; opMode = m; srcReq = '0; irqAck = 1'b0;
    step(); step();
    expectOut("R10 in reset", 1'b0, 0);
    rstN = 1'b1;
    step();
    expectOut("R3 R10 reset cause", 1'b1, cop ? 1 : 0);
    ackOne();
    expectOut("R10 only cause pending", 1'b0, 0);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 2; c++) begin
        doReset(c[0], 2'(m));
        // R2 R3 each source alone in this mode
        for (int s = 0; s < NS; s++) begin
          pulse(s);
          expectOut("R2 R9 single", 1'b1, s);
          ackOne();
          expectOut("R11 idle after ack", 1'b0, 0);
        end
      end
    end
    opMode = 2'd1;
    // R1 priority over all pairs
    for (int i = 0; i < NS; i++) begin
      for (int j = i + 1; j < NS; j++) begin
        srcReq[i] = 1'b1; srcReq[j] = 1'b1;
        step();
        srcReq = '0;
        expectOut("R1 pair winner", 1'b1, i);
        ackOne();
        expectOut("R9 next after ack", 1'b1, j);
        ackOne();
        expectOut("R8 both cleared", 1'b0, 0);
      end
    end
    // R5 R6 enable gating, R8 pending kept
    for (int s = 6; s < NS; s++) begin
      prioReg = CFG_ALL & ~enBits(s);
      pulse(s);
      expectOut("R5 R6 disabled", 1'b0, 0);
      prioReg = CFG_ALL;
      step();
      expectOut("R8 kept while disabled", 1'b1, s);
      ackOne();
    end
    // R6 bit 10 alone enables nothing
    prioReg = 16'h0400;
    for (int s = 6; s < NS; s++) begin
      pulse(s);
      expectOut("R6 unused channel bit", 1'b0, 0);
    end
    prioReg = CFG_ALL;
    step();
    expectOut("R1 lowest index after enable", 1'b1, 6);
    for (int s = 6; s < NS; s++) ackOne();
    expectOut("R8 all acked", 1'b0, 0);
    // R5 every nonzero field value
    for (int f = 1; f < 4; f++) begin
      prioReg = (CFG_ALL & ~16'h0006) | 16'(f << 1);
      pulse(6);
      expectOut("R5 field A", 1'b1, 6);
      ackOne();
      prioReg = (CFG_ALL & ~16'h0030) | 16'(f << 4);
      pulse(7);
      expectOut("R5 field B", 1'b1, 7);
      ackOne();
    end
    prioReg = CFG_ALL;
    // R7 mask
    coreMask = 1'b1;
    pulse(18);
    expectOut("R7 masked level0", 1'b0, 0);
    pulse(2);
    expectOut("R7 level1 under mask", 1'b1, 2);
    ackOne();
    expectOut("R7 still masked", 1'b0, 0);
    coreMask = 1'b0;
    step();
    expectOut("R7 unmasked", 1'b1, 18);
    ackOne();
    // R8 held request does not re-set
    srcReq[3] = 1'b1;
    step();
    expectOut("R8 held rise", 1'b1, 3);
    ackOne();
    expectOut("R8 held no reset", 1'b0, 0);
    step();
    expectOut("R8 held stays clear", 1'b0, 0);
    srcReq[3] = 1'b0;
    // R8 ack with nothing presented has no effect
    irqAck = 1'b1;
    step();
    irqAck = 1'b0;
    coreMask = 1'b1;
    pulse(17);
    irqAck = 1'b1;
    step();
    irqAck = 1'b0;
    coreMask = 1'b0;
    step();
    expectOut("R8 ack ignored when idle", 1'b1, 17);
    ackOne();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule